// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block produces the interrupt identification status of one UART channel that has a 16-byte receive FIFO. Five interrupt sources feed it. Three arrive as event pulses and are held in latches until they are cleared: receive line error, transmit holding register empty, and modem status change. The other two are levels derived from the FIFO fill count, which is an input: receive data ready and receive time-out. Each source passes through its own enable bit. A fixed-priority state machine then picks one source to report.

Software reads an 8-bit status byte through a single read strobe. The byte names only the highest-priority source that is pending. The read acknowledges that source and no other, so a lower-priority source appears on the next read. The interrupt pin is high while the state machine holds any pending source.

The state machine has the states ST_NONE, ST_LINE, ST_RXDATA, ST_TIMEOUT, ST_TXEMPTY and ST_MODEM. On every clock it moves to the state of the highest-priority enabled source in the next-cycle pending set, or to ST_NONE when that set is empty. Any state can move to any other state. A status read in ST_LINE, ST_TXEMPTY or ST_MODEM clears that latch, and this takes the state to the next source down in the same edge.

Top module: `uart_irq_id`

## Requirements
- R1: Status bits [7:6] read 11 when `fifo_en` was 1 in the read cycle and 00 otherwise. Bits [5:4] always read 0.
- R2: Bit 0 of the status is 0 when a source is reported and 1 when none is. After reset, `rd_data` is 0x01 and `irq` is 0.
- R3: Priority and the codes in bits [3:0] are fixed, highest first: line error 0110, receive data ready 0100, receive time-out 1100, transmit empty 0010, modem change 0000. No pending source gives 0001.
- R4: A status read returns only the highest-priority pending source. If that source is line error, transmit empty or modem change, the read clears it, and the next lower pending source is reported on the next read. The receive sources are not cleared by a status read.
- R5: Receive data ready is pending when `rx_count` is at or above a threshold. With `fifo_en`=1 the threshold follows `trig_sel`: 0→1, 1→4, 2→8, 3→14. With `fifo_en`=0 the threshold is 1.
- R6: Receive time-out becomes pending when all of these hold: `fifo_en`=1, `rx_count` is non-zero and below the threshold, and neither `rx_push` nor `rx_pop` has occurred for 4 character times (CHAR_CYCLES clocks each). A `rx_pop` clears it.
- R7: `src_en` gates the sources: bit0 both receive sources, bit1 transmit empty, bit2 line error, bit3 modem change. A source whose enable bit is 0 is not reported and does not drive `irq`. Its latch still holds the event, and the event is reported once the bit is set.
- R8: `lsr_rd` clears the line error latch, `msr_rd` clears the modem latch, and `thr_wr` clears the transmit empty latch.
- R9: If an event arrives in the same cycle as a clear or acknowledge of its latch, the event wins and stays pending. `rd_data` captures the status at the clock edge of the read strobe.
- R10: `irq` is 1 while an enabled source is pending, and is 0 one cycle after all enables are 0.
- R11: `rd_data` holds its value when `rd_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive trigger threshold select |
| src_en | input | 4 | Per-source enables (see R7) |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | A byte entered the receive FIFO |
| rx_pop | input | 1 | A byte was read from the receive FIFO |
| line_err_evt | input | 1 | Receive line error event |
| lsr_rd | input | 1 | Line status register was read |
| tx_empty_evt | input | 1 | Transmit holding register became empty |
| thr_wr | input | 1 | Transmit holding register was written |
| modem_evt | input | 1 | Modem status change event |
| msr_rd | input | 1 | Modem status register was read |
| rd_stb | input | 1 | Status read strobe |
| rd_data | output | 8 | Status byte captured on the read |
| irq | output | 1 | Interrupt request |

## Verification
A status read, which acknowledges the reported source, can fall in the same clock as a new event for that same source. The bench provokes this by pulsing `tx_empty_evt` together with `rd_stb` while transmit empty is the reported source. The read must return the transmit empty code. The following read must return it again, because the new event survives the acknowledge. Only the read after that may report no source.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        ST_NONE,
        ST_MODEM,
        ST_TXEMPTY,
        ST_TIMEOUT,
        ST_RXDATA,
        ST_LINE
    } irq_state_e;

    // indices into the pending vector, highest priority at the top
    localparam int P_MODEM   = 0;
    localparam int P_TXEMPTY = 1;
    localparam int P_TIMEOUT = 2;
    localparam int P_RXDATA  = 3;
    localparam int P_LINE    = 4;
    localparam int NUM_PEND  = 5;

    // latched event sources
    localparam int L_LINE   = 0;
    localparam int L_TX     = 1;
    localparam int L_MODEM  = 2;
    localparam int NUM_LAT  = 3;

    function automatic logic [3:0] state_code(irq_state_e s);
        logic [3:0] c;
        unique case (s)
            ST_LINE:    c = 4'b0110;
            ST_RXDATA:  c = 4'b0100;
            ST_TIMEOUT: c = 4'b1100;
            ST_TXEMPTY: c = 4'b0010;
            ST_MODEM:   c = 4'b0000;
            ST_NONE:    c = 4'b0001;
            default:    c = 4'b0001;
        endcase
        return c;
    endfunction

    function automatic int unsigned trig_level(logic en, logic [1:0] sel);
        int unsigned t;
        if (!en) begin
            t = 1;
        end else begin
            unique case (sel)
                2'd0: t = 1;
                2'd1: t = 4;
                2'd2: t = 8;
                2'd3: t = 14;
                default: t = 1;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q,
    output logic [N-1:0] d
);
    for (genvar i = 0; i < N; i++) begin : g_lat
        // a new event outranks a clear in the same cycle
        assign d[i] = set[i] | (q[i] & ~clr[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
        end
    end
endmodule

// File: rtl/irq_rx_watch.sv
module irq_rx_watch
    import irq_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int CHAR_CYCLES = 10,
    parameter int TO_CHARS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    output logic             rx_ready,
    output logic             to_d
);
    localparam int LIMIT = CHAR_CYCLES * TO_CHARS;
    localparam int IW    = $clog2(LIMIT + 1);
    localparam logic [IW-1:0] LIMIT_V = IW'(LIMIT);

    logic [CNT_W-1:0] thr;
    logic [IW-1:0]    idle_cnt;
    logic             to_q;
    logic             below;
    logic             idle_reset;

    assign thr      = CNT_W'(trig_level(fifo_en, trig_sel));
    assign rx_ready = (rx_count >= thr);
    assign below    = (rx_count != '0) && (rx_count < thr);

    assign idle_reset = rx_push | rx_pop | (rx_count == '0) | ~fifo_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  idle_cnt <= '0;
        else if (idle_reset)         idle_cnt <= '0;
        else if (idle_cnt != LIMIT_V) idle_cnt <= idle_cnt + 1'b1;
    end

    assign to_d = fifo_en & ~rx_pop &
                  (to_q | ((idle_cnt == LIMIT_V) & below));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) to_q <= 1'b0;
        else        to_q <= to_d;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PEND-1:0] pend_next,
    input  logic                fifo_en,
    input  logic                rd_stb,
    output logic [NUM_LAT-1:0]  ack,
    output logic [7:0]          rd_data,
    output logic                irq
);
    irq_state_e cur, nxt;

    always_comb begin
        if      (pend_next[P_LINE])    nxt = ST_LINE;
        else if (pend_next[P_RXDATA])  nxt = ST_RXDATA;
        else if (pend_next[P_TIMEOUT]) nxt = ST_TIMEOUT;
        else if (pend_next[P_TXEMPTY]) nxt = ST_TXEMPTY;
        else if (pend_next[P_MODEM])   nxt = ST_MODEM;
        else                           nxt = ST_NONE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_NONE;
        else        cur <= nxt;
    end

    // acknowledge of the reported latched source
    always_comb begin
        ack = '0;
        unique case (cur)
            ST_LINE:    ack[L_LINE]  = rd_stb;
            ST_TXEMPTY: ack[L_TX]    = rd_stb;
            ST_MODEM:   ack[L_MODEM] = rd_stb;
            ST_RXDATA, ST_TIMEOUT, ST_NONE: ack = '0;
            default:    ack = '0;
        endcase
    end

    assign irq = (cur != ST_NONE);

    // output register: status captured at the read edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= 8'h01;
        else if (rd_stb) rd_data <= {{2{fifo_en}}, 2'b00, state_code(cur)};
    end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import irq_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int CHAR_CYCLES = 10,
    parameter int TO_CHARS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [3:0]       src_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             line_err_evt,
    input  logic             lsr_rd,
    input  logic             tx_empty_evt,
    input  logic             thr_wr,
    input  logic             modem_evt,
    input  logic             msr_rd,
    input  logic             rd_stb,
    output logic [7:0]       rd_data,
    output logic             irq
);
    logic [NUM_LAT-1:0]  lat_set, lat_clr, lat_q, lat_d, ack;
    logic [NUM_PEND-1:0] pend_next;
    logic                rx_ready, to_d;

    assign lat_set[L_LINE]  = line_err_evt;
    assign lat_set[L_TX]    = tx_empty_evt;
    assign lat_set[L_MODEM] = modem_evt;
    assign lat_clr[L_LINE]  = lsr_rd | ack[L_LINE];
    assign lat_clr[L_TX]    = thr_wr | ack[L_TX];
    assign lat_clr[L_MODEM] = msr_rd | ack[L_MODEM];

    irq_evt_latch #(.N(NUM_LAT)) u_lat (
        .clk(clk), .rst_n(rst_n), .set(lat_set), .clr(lat_clr),
        .q(lat_q), .d(lat_d)
    );

    irq_rx_watch #(
        .CNT_W(CNT_W), .CHAR_CYCLES(CHAR_CYCLES), .TO_CHARS(TO_CHARS)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
        .rx_ready(rx_ready), .to_d(to_d)
    );

    assign pend_next[P_LINE]    = lat_d[L_LINE]  & src_en[2];
    assign pend_next[P_RXDATA]  = rx_ready       & src_en[0];
    assign pend_next[P_TIMEOUT] = to_d           & src_en[0];
    assign pend_next[P_TXEMPTY] = lat_d[L_TX]    & src_en[1];
    assign pend_next[P_MODEM]   = lat_d[L_MODEM] & src_en[3];

    irq_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .pend_next(pend_next), .fifo_en(fifo_en),
        .rd_stb(rd_stb), .ack(ack), .rd_data(rd_data), .irq(irq)
    );

    logic unused_q;
    assign unused_q = ^lat_q;
endmodule

// File: rtl/irq_sva.sv
module irq_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic [3:0] src_en,
    input logic       line_err_evt,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       irq
);
    assert_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[7:4] == {{2{$past(fifo_en)}}, 2'b00});

    assert_pending_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && irq) |=> rd_data[0] == 1'b0);

    assert_none_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !irq) |=> rd_data[3:0] == 4'b0001);

    assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == 4'b0000) |=> !irq);

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_evt && src_en[2]) |=> irq);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

bind uart_irq_id irq_sva u_sva (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
    .line_err_evt(line_err_evt), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_uart_irq_id.sv
`timescale 1ns/1ps
module sim_uart_irq_id;
    localparam int CNT_W = 5;

    logic clk = 0, rst_n = 0;
    logic fifo_en = 0;
    logic [1:0] trig_sel = 0;
    logic [3:0] src_en = 0;
    logic [CNT_W-1:0] rx_count = 0;
    logic rx_push = 0, rx_pop = 0, line_err_evt = 0, lsr_rd = 0;
    logic tx_empty_evt = 0, thr_wr = 0, modem_evt = 0, msr_rd = 0, rd_stb = 0;
    logic [7:0] rd_data;
    logic irq;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    uart_irq_id #(.CNT_W(CNT_W), .CHAR_CYCLES(10), .TO_CHARS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .src_en(src_en), .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
        .line_err_evt(line_err_evt), .lsr_rd(lsr_rd), .tx_empty_evt(tx_empty_evt),
        .thr_wr(thr_wr), .modem_evt(modem_evt), .msr_rd(msr_rd), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq(irq)
    );

    // {trig_sel[1:0], 1'b0, rx_count[4:0], expected status[7:0]}, R5
    localparam logic [15:0] VEC [9] = '{
        {2'd0, 1'b0, 5'd0,  8'hC1}, {2'd0, 1'b0, 5'd1,  8'hC4},
        {2'd1, 1'b0, 5'd3,  8'hC1}, {2'd1, 1'b0, 5'd4,  8'hC4},
        {2'd2, 1'b0, 5'd7,  8'hC1}, {2'd2, 1'b0, 5'd8,  8'hC4},
        {2'd3, 1'b0, 5'd13, 8'hC1}, {2'd3, 1'b0, 5'd14, 8'hC4},
        {2'd3, 1'b0, 5'd16, 8'hC4}
    };

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(string tag, logic [7:0] exp);
        rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R2 reset state
        check("R2 reset rd_data", rd_data, 8'h01);
        check("R2 reset irq", {7'd0, irq}, 8'h00);
        do_read("R2 R1 idle read, fifo off", 8'h01);

        // R5 trigger table
        fifo_en = 1; src_en = 4'b0001;
        for (int i = 0; i < 9; i++) begin
            trig_sel = VEC[i][15:14];
            rx_count = VEC[i][12:8];
            rx_pop = 1; step(1); rx_pop = 0;
            do_read($sformatf("R5 vector %0d", i), VEC[i][7:0]);
        end
        rx_count = 0; rx_pop = 1; step(1); rx_pop = 0;

        // R5 threshold is 1 when FIFOs are off; R1 top bits 00
        fifo_en = 0; trig_sel = 3; rx_count = 1; step(1);
        do_read("R5 R1 fifo off threshold", 8'h04);
        rx_count = 0; fifo_en = 1; step(1);

        // R3 R4 priority walk
        src_en = 4'b1111; trig_sel = 1; rx_count = 4;
        line_err_evt = 1; tx_empty_evt = 1; modem_evt = 1; step(1);
        line_err_evt = 0; tx_empty_evt = 0; modem_evt = 0;
        check("R10 irq with pending", {7'd0, irq}, 8'h01);
        do_read("R3 line first", 8'hC6);
        do_read("R4 rx data after line ack", 8'hC4);
        do_read("R4 rx data not cleared by read", 8'hC4);
        rx_count = 0; step(1);
        do_read("R3 tx empty", 8'hC2);
        do_read("R3 modem lowest", 8'hC0);
        do_read("R4 none left", 8'hC1);
        step(3);
        check("R11 rd_data holds", rd_data, 8'hC1);

        // R6 time-out
        trig_sel = 3; rx_count = 3;
        rx_push = 1; step(1); rx_push = 0;
        step(20);
        do_read("R6 not yet timed out", 8'hC1);
        step(30);
        do_read("R6 timed out", 8'hCC);
        rx_pop = 1; step(1); rx_pop = 0;
        do_read("R6 cleared by pop", 8'hC1);
        rx_count = 0; step(1);

        // R7 enable gating
        src_en = 4'b0000;
        line_err_evt = 1; step(1); line_err_evt = 0;
        step(1);
        check("R7 disabled no irq", {7'd0, irq}, 8'h00);
        do_read("R7 disabled not reported", 8'hC1);
        src_en = 4'b0100; step(1);
        check("R7 enabled raises irq", {7'd0, irq}, 8'h01);
        do_read("R7 latched then reported", 8'hC6);
        src_en = 4'b1111;

        // R8 dedicated clears
        line_err_evt = 1; step(1); line_err_evt = 0;
        lsr_rd = 1; step(1); lsr_rd = 0;
        do_read("R8 lsr read clears", 8'hC1);
        tx_empty_evt = 1; step(1); tx_empty_evt = 0;
        thr_wr = 1; step(1); thr_wr = 0;
        do_read("R8 holding write clears", 8'hC1);
        modem_evt = 1; step(1); modem_evt = 0;
        msr_rd = 1; step(1); msr_rd = 0;
        do_read("R8 msr read clears", 8'hC1);

        // R9 event in the same cycle as its acknowledge
        tx_empty_evt = 1; step(1); tx_empty_evt = 0;
        rd_stb = 1; tx_empty_evt = 1; step(1);
        rd_stb = 0; tx_empty_evt = 0;
        check("R9 read captures tx", rd_data, 8'hC2);
        do_read("R9 event survived ack", 8'hC2);
        do_read("R9 then none", 8'hC1);
        step(1);
        check("R10 irq low when idle", {7'd0, irq}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule